// File: doc/BRIEF.md
# Multi-Register Transfer Sequencer

This block walks a 16-bit register mask and moves the selected registers between a register file of eight data and eight address registers and memory. Each transfer is one beat, either a word (16 bits) or a long (32 bits). A start strobe loads the direction, size, addressing mode, mask and start address. The block then issues one memory request per set mask bit. It only advances when memory signals ready. When it finishes, it reports the final address, whether the base register must take that address, and the total cycle cost of the transfer.

The starting address comes already computed from outside. The memory and the register file also sit outside, and the block only drives their ports. The register file port is numbered 0 to 7 for the data registers and 8 to 15 for the address registers. Reads from it are combinational, so the store data is valid in the same cycle as the index.

Top module: `mreg_xfer_seq`

## Requirements
- R1: In register-to-memory direction (`load_i`=0), mask bits are visited from bit 0 upward. Bit k selects register-file index 15-k: bits 0..7 select address registers A7..A0 (index 15..8), and bits 8..15 select data registers D7..D0 (index 7..0).
- R2: In register-to-memory direction with `mode_i`=4 (predecrement), the address drops by the size before each store, and the store goes to the lowered address. The final address is reported with `wb_en_o`=1.
- R3: In register-to-memory direction with any other mode, each store goes to the current address, and the address then rises by the size (2 for word, 4 for long). `wb_en_o` stays 0.
- R4: In memory-to-register direction (`load_i`=1), mask bit k selects register-file index k, visited from bit 0 upward. The address rises by the size after each load, and `rf_we_o` is high only in the cycle a load is accepted.
- R5: In memory-to-register direction, `wb_en_o` is 1 at completion only for `mode_i`=3 (postincrement).
- R6: A long load writes all 32 bits of `mem_rdata_i` to the register. A word load writes bits 15:0 sign-extended from bit 15 into bits 31:16.
- R7: `cycles_o` equals the base cost plus 4 per register for word, or 8 per register for long. The base cost is the following:
  - register-to-memory: 8 for modes 2, 3 and 4, 12 for modes 5 and 7, and 14 for mode 6.
  - memory-to-register: 12 for modes 2, 3 and 4, 16 for modes 5 and 7, and 18 for mode 6.
  - Modes 0 and 1 have a base of 0.
- R8: An all-zero mask issues no memory request and reports only the base cost. It reports the unchanged start address as the final address, with writeback as R2/R5 dictate.
- R9: While `mem_req_o` is high and `mem_ready_i` is low, the request, its address and its register index hold steady into the next cycle.
- R10: `busy_o` is high from the cycle after an accepted start through the cycle of `done_o`. `done_o` is a single-cycle pulse, and `mem_req_o` is never high without `busy_o`.
- R11: A store drives `mem_wdata_o` with the full register for long. For word it drives the register's low 16 bits with the upper 16 bits zero. `mem_long_o` gives the size, and `mem_we_o`=1 marks a store.
- R12: A start strobe while `busy_o` is high is ignored, so the transfer in flight completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a transfer (accepted when idle) |
| load_i | input | 1 | 1 = memory to registers, 0 = registers to memory |
| long_i | input | 1 | 1 = 32-bit beats, 0 = 16-bit beats |
| mode_i | input | 3 | Addressing mode (3 postincrement, 4 predecrement) |
| mask_i | input | 16 | Register selection mask |
| addr_i | input | 32 | Start address |
| rf_rdata_i | input | 32 | Register-file read data for `rf_idx_o` |
| rf_idx_o | output | 4 | Register-file index (0-7 data, 8-15 address) |
| rf_we_o | output | 1 | Register-file write enable |
| rf_wdata_o | output | 32 | Register-file write data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a store |
| mem_long_o | output | 1 | Request size is long |
| mem_addr_o | output | 32 | Request address |
| mem_wdata_o | output | 32 | Store data |
| mem_rdata_i | input | 32 | Load data for the current request |
| mem_ready_i | input | 1 | Memory accepts the current request at the next edge |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wb_en_o | output | 1 | Base register takes `final_addr_o` (with `done_o`) |
| final_addr_o | output | 32 | Address after the last beat |
| cycles_o | output | 8 | Total cycle cost of the last transfer |

## Verification
The bench builds the block with its default parameters: eight registers per bank and 32-bit data and addresses. This keeps every register index, both scan orders and the full 16-bit mask in reach. It sweeps both directions, both sizes and modes 2 through 7 against the empty mask, the full mask, all sixteen single-bit masks and several mixed patterns. A pseudo-random ready pattern exercises stalls on every beat position. Expected addresses, indices, data, final address and cycle cost are computed arithmetically from the requirements.

// File: rtl/mrx_pkg.sv
// Shared types and mode codes for the multi-register transfer sequencer.
// Assumes a 3-bit addressing-mode field in which two codes change behaviour.
package mrx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } mrx_state_e;

    localparam logic [2:0] MODE_POSTINC = 3'd3;
    localparam logic [2:0] MODE_PREDEC  = 3'd4;

endpackage

// File: rtl/mrx_pick.sv
// Lowest-set-bit finder for the remaining register mask.
// Assumes N >= 2; idx_o is 0 when no bit is set.
module mrx_pick #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    // Priority scan: the lowest set bit wins.
    always_comb begin
        any_o = |vec_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
    end

endmodule

// File: rtl/mrx_step.sv
// Address stepper: the issue address and the following address for one beat.
// Assumes byte addressing; a beat spans WORD_BYTES or LONG_BYTES.
module mrx_step #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 2,
    parameter int LONG_BYTES = 4
) (
    input  logic [ADDR_W-1:0] cur_i,
    input  logic              long_i,
    input  logic              predec_i,
    output logic [ADDR_W-1:0] issue_o,
    output logic [ADDR_W-1:0] next_o
);

    logic [ADDR_W-1:0] step;

    // Beat size in bytes.
    assign step = long_i ? ADDR_W'(LONG_BYTES) : ADDR_W'(WORD_BYTES);

    // Predecrement lowers before the access; other modes raise after it.
    always_comb begin
        if (predec_i) begin
            issue_o = cur_i - step;
            next_o  = cur_i - step;
        end else begin
            issue_o = cur_i;
            next_o  = cur_i + step;
        end
    end

endmodule

// File: rtl/mrx_cost.sv
// Cycle-cost calculator: mode-dependent base plus a per-register charge.
// Assumes the register count fits CNT_W and the result fits CYC_W.
module mrx_cost #(
    parameter int CNT_W     = 5,
    parameter int CYC_W     = 8,
    parameter int WORD_COST = 4,
    parameter int LONG_COST = 8
) (
    input  logic             load_i,
    input  logic             long_i,
    input  logic [2:0]       mode_i,
    input  logic [CNT_W-1:0] nregs_i,
    output logic [CYC_W-1:0] cycles_o
);

    logic [CYC_W-1:0] base;
    logic [CYC_W-1:0] per_reg;

    // Base cost chosen by direction and mode.
    always_comb begin
        case (mode_i)
            3'd2, 3'd3, 3'd4: base = load_i ? CYC_W'(12) : CYC_W'(8);
            3'd5, 3'd7:       base = load_i ? CYC_W'(16) : CYC_W'(12);
            3'd6:             base = load_i ? CYC_W'(18) : CYC_W'(14);
            default:          base = '0;
        endcase
    end

    // Per-register charge by size.
    assign per_reg  = long_i ? CYC_W'(LONG_COST) : CYC_W'(WORD_COST);
    assign cycles_o = base + CYC_W'(nregs_i) * per_reg;

endmodule

// File: rtl/mreg_xfer_seq.sv
// Multi-register transfer sequencer top.
// Walks a register mask and issues one memory beat per set bit. It holds each
// request until memory is ready, then reports the final address, the writeback
// flag and the cycle cost. Assumes a combinational register-file read port.
module mreg_xfer_seq #(
    parameter int NBANK  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CYC_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      load_i,
    input  logic                      long_i,
    input  logic [2:0]                mode_i,
    input  logic [2*NBANK-1:0]        mask_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [DATA_W-1:0]         rf_rdata_i,
    output logic [$clog2(2*NBANK)-1:0] rf_idx_o,
    output logic                      rf_we_o,
    output logic [DATA_W-1:0]         rf_wdata_o,
    output logic                      mem_req_o,
    output logic                      mem_we_o,
    output logic                      mem_long_o,
    output logic [ADDR_W-1:0]         mem_addr_o,
    output logic [DATA_W-1:0]         mem_wdata_o,
    input  logic [DATA_W-1:0]         mem_rdata_i,
    input  logic                      mem_ready_i,
    output logic                      busy_o,
    output logic                      done_o,
    output logic                      wb_en_o,
    output logic [ADDR_W-1:0]         final_addr_o,
    output logic [CYC_W-1:0]          cycles_o
);
    import mrx_pkg::*;

    localparam int NREG  = 2 * NBANK;
    localparam int IDX_W = $clog2(NREG);
    localparam int CNT_W = $clog2(NREG + 1);
    localparam int HALF  = DATA_W / 2;

    mrx_state_e          state;
    logic [NREG-1:0]     rem;
    logic [ADDR_W-1:0]   cur_addr;
    logic                load_q;
    logic                long_q;
    logic [2:0]          mode_q;
    logic [CNT_W-1:0]    cnt;
    logic                wb_q;
    logic [ADDR_W-1:0]   final_q;
    logic [CYC_W-1:0]    cycles_q;

    logic                any_left;
    logic [IDX_W-1:0]    bit_idx;
    logic                predec;
    logic [ADDR_W-1:0]   issue_addr;
    logic [ADDR_W-1:0]   next_addr;
    logic [CYC_W-1:0]    cost;
    logic                wb_cond;
    logic                beat_go;

    mrx_pick #(.N(NREG), .IDX_W(IDX_W)) u_pick (
        .vec_i (rem),
        .any_o (any_left),
        .idx_o (bit_idx)
    );

    // Predecrement applies only to stores.
    assign predec = !load_q && (mode_q == MODE_PREDEC);

    mrx_step #(.ADDR_W(ADDR_W), .WORD_BYTES(HALF / 8), .LONG_BYTES(DATA_W / 8)) u_step (
        .cur_i    (cur_addr),
        .long_i   (long_q),
        .predec_i (predec),
        .issue_o  (issue_addr),
        .next_o   (next_addr)
    );

    mrx_cost #(.CNT_W(CNT_W), .CYC_W(CYC_W)) u_cost (
        .load_i   (load_q),
        .long_i   (long_q),
        .mode_i   (mode_q),
        .nregs_i  (cnt),
        .cycles_o (cost)
    );

    // Writeback applies to predecrement stores and postincrement loads.
    assign wb_cond = predec || (load_q && mode_q == MODE_POSTINC);

    // A beat completes when a request is out and memory is ready.
    assign beat_go = mem_req_o && mem_ready_i;

    // Sequencer state, remaining mask, running address and results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            rem      <= '0;
            cur_addr <= '0;
            load_q   <= 1'b0;
            long_q   <= 1'b0;
            mode_q   <= '0;
            cnt      <= '0;
            wb_q     <= 1'b0;
            final_q  <= '0;
            cycles_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        state    <= ST_RUN;
                        rem      <= mask_i;
                        cur_addr <= addr_i;
                        load_q   <= load_i;
                        long_q   <= long_i;
                        mode_q   <= mode_i;
                        cnt      <= '0;
                    end
                end
                ST_RUN: begin
                    if (any_left) begin
                        if (beat_go) begin
                            rem      <= rem & (rem - NREG'(1));
                            cur_addr <= next_addr;
                            cnt      <= cnt + CNT_W'(1);
                        end
                    end else begin
                        state    <= ST_FIN;
                        final_q  <= cur_addr;
                        wb_q     <= wb_cond;
                        cycles_q <= cost;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Register-file index: loads map bit k to k, stores map it to NREG-1-k.
    assign rf_idx_o = load_q ? bit_idx : IDX_W'(NREG - 1) - bit_idx;

    // Memory request and register-file write drive.
    always_comb begin
        mem_req_o   = (state == ST_RUN) && any_left;
        mem_we_o    = mem_req_o && !load_q;
        mem_long_o  = long_q;
        mem_addr_o  = issue_addr;
        mem_wdata_o = long_q ? rf_rdata_i : {{HALF{1'b0}}, rf_rdata_i[HALF-1:0]};
        rf_we_o     = mem_req_o && load_q && mem_ready_i;
        rf_wdata_o  = long_q ? mem_rdata_i
                             : {{HALF{mem_rdata_i[HALF-1]}}, mem_rdata_i[HALF-1:0]};
    end

    // Status and completion outputs.
    assign busy_o       = (state != ST_IDLE);
    assign done_o       = (state == ST_FIN);
    assign wb_en_o      = (state == ST_FIN) && wb_q;
    assign final_addr_o = final_q;
    assign cycles_o     = cycles_q;

endmodule

// File: rtl/mreg_xfer_seq_chk.sv
// Protocol checker for the transfer sequencer, bound to every instance.
// Assumes the port names and widths of mreg_xfer_seq.
module mreg_xfer_seq_chk #(
    parameter int IDX_W  = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W-1:0]  rf_idx_o,
    input logic              rf_we_o,
    input logic [DATA_W-1:0] rf_wdata_o,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic              mem_long_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_ready_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              wb_en_o
);
    localparam int HALF = DATA_W / 2;

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    p_req_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> busy_o);

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=>
            (mem_req_o && $stable(mem_addr_o) && $stable(rf_idx_o)));

    p_rf_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> (mem_req_o && mem_ready_i && !mem_we_o));

    p_wb_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> done_o);

    p_word_sext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_o && !mem_long_o) |->
            (rf_wdata_o[DATA_W-1:HALF] == {HALF{rf_wdata_o[HALF-1]}}));

endmodule

bind mreg_xfer_seq mreg_xfer_seq_chk #(
    .IDX_W  ($clog2(2 * NBANK)),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rf_idx_o    (rf_idx_o),
    .rf_we_o     (rf_we_o),
    .rf_wdata_o  (rf_wdata_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_long_o  (mem_long_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ready_i (mem_ready_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .wb_en_o     (wb_en_o)
);

// File: tb/mreg_xfer_seq_tb.sv
// Sweep bench for mreg_xfer_seq. The memory and register-file models are
// arithmetic functions, and expected beats are computed from the requirements.
module mreg_xfer_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        load_i = 1'b0;
    logic        long_i = 1'b0;
    logic [2:0]  mode_i = 3'd0;
    logic [15:0] mask_i = '0;
    logic [31:0] addr_i = '0;
    logic [31:0] rf_rdata_i;
    logic [3:0]  rf_idx_o;
    logic        rf_we_o;
    logic [31:0] rf_wdata_o;
    logic        mem_req_o;
    logic        mem_we_o;
    logic        mem_long_o;
    logic [31:0] mem_addr_o;
    logic [31:0] mem_wdata_o;
    logic [31:0] mem_rdata_i;
    logic        mem_ready_i = 1'b0;
    logic        busy_o;
    logic        done_o;
    logic        wb_en_o;
    logic [31:0] final_addr_o;
    logic [7:0]  cycles_o;

    int   n_checks = 0;
    int   n_fail = 0;
    int   cyc = 0;
    logic [7:0] lfsr = 8'h5B;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] rf_model(input logic [3:0] i);
        return 32'hC0DE_8000 ^ ({28'd0, i} * 32'h0001_1111);
    endfunction

    function automatic logic [31:0] mem_model(input logic [31:0] a);
        return a * 32'h9E37_79B1;
    endfunction

    assign rf_rdata_i  = rf_model(rf_idx_o);
    assign mem_rdata_i = mem_model(mem_addr_o);

    mreg_xfer_seq u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .load_i       (load_i),
        .long_i       (long_i),
        .mode_i       (mode_i),
        .mask_i       (mask_i),
        .addr_i       (addr_i),
        .rf_rdata_i   (rf_rdata_i),
        .rf_idx_o     (rf_idx_o),
        .rf_we_o      (rf_we_o),
        .rf_wdata_o   (rf_wdata_o),
        .mem_req_o    (mem_req_o),
        .mem_we_o     (mem_we_o),
        .mem_long_o   (mem_long_o),
        .mem_addr_o   (mem_addr_o),
        .mem_wdata_o  (mem_wdata_o),
        .mem_rdata_i  (mem_rdata_i),
        .mem_ready_i  (mem_ready_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .wb_en_o      (wb_en_o),
        .final_addr_o (final_addr_o),
        .cycles_o     (cycles_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int base_cost(input bit ld, input logic [2:0] m);
        case (m)
            3'd2, 3'd3, 3'd4: return ld ? 12 : 8;
            3'd5, 3'd7:       return ld ? 16 : 12;
            3'd6:             return ld ? 18 : 14;
            default:          return 0;
        endcase
    endfunction

    task automatic run_xfer(input bit ld, input bit lng, input logic [2:0] m,
                            input logic [15:0] mk, input logic [31:0] base);
        logic [3:0]  ei[16];
        logic [31:0] ea[16];
        logic [31:0] a = base;
        logic [31:0] step = lng ? 32'd4 : 32'd2;
        logic [31:0] prev_addr = '0;
        logic [31:0] exp_d;
        int n = 0;
        int k = 0;
        int waited = 0;
        bit seen = 0;
        bit stalled = 0;
        bit exp_wb;
        int exp_cyc;
        for (int b = 0; b < 16; b++) begin
            if (mk[b]) begin
                ei[n] = ld ? 4'(b) : 4'(15 - b);
                if (!ld && m == 3'd4) begin
                    a = a - step;
                    ea[n] = a;
                end else begin
                    ea[n] = a;
                    a = a + step;
                end
                n++;
            end
        end
        exp_cyc = base_cost(ld, m) + n * (lng ? 8 : 4);
        exp_wb  = (!ld && m == 3'd4) || (ld && m == 3'd3);

        @(negedge clk);
        start_i = 1'b1; load_i = ld; long_i = lng; mode_i = m;
        mask_i = mk; addr_i = base;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R10 busy after start", 32'(busy_o), 32'd1);

        while (!seen && waited < 300) begin
            if (done_o) begin
                seen = 1;
                start_i = 1'b0;
                check(k == n, "R8/R12 beat count", 32'(k), 32'(n));
                check(cycles_o == 8'(exp_cyc), "R7 cycle cost", 32'(cycles_o), 32'(exp_cyc));
                check(final_addr_o == a, "R2/R3/R4 final address", final_addr_o, a);
                check(wb_en_o == exp_wb, "R5/R2 writeback flag", 32'(wb_en_o), 32'(exp_wb));
            end else begin
                if (stalled)
                    check(mem_req_o && mem_addr_o == prev_addr, "R9 hold on stall",
                          mem_addr_o, prev_addr);
                // R12: a second start while busy must change nothing.
                if (waited == 0) begin
                    start_i = 1'b1; mask_i = 16'hFFFF; addr_i = 32'hDEAD_0000;
                    load_i = ~ld; long_i = ~lng;
                end else begin
                    start_i = 1'b0;
                end
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                mem_ready_i = lfsr[0] | lfsr[1];
                #1;
                if (mem_req_o && mem_ready_i) begin
                    if (k >= n) begin
                        check(1'b0, "R8 extra memory request", mem_addr_o, 32'hFFFF_FFFF);
                    end else begin
                        check(mem_addr_o == ea[k], "R1-order/R2/R3/R4 beat address",
                              mem_addr_o, ea[k]);
                        check(rf_idx_o == ei[k], "R1/R4 register index",
                              32'(rf_idx_o), 32'(ei[k]));
                        check(mem_we_o == !ld && mem_long_o == lng, "R11 request kind",
                              {30'd0, mem_we_o, mem_long_o}, {30'd0, !ld, lng});
                        if (ld) begin
                            exp_d = mem_model(ea[k]);
                            if (!lng) exp_d = {{16{exp_d[15]}}, exp_d[15:0]};
                            check(rf_we_o && rf_wdata_o == exp_d, "R6 load data",
                                  rf_wdata_o, exp_d);
                        end else begin
                            exp_d = rf_model(ei[k]);
                            if (!lng) exp_d = {16'd0, exp_d[15:0]};
                            check(!rf_we_o && mem_wdata_o == exp_d, "R11 store data",
                                  mem_wdata_o, exp_d);
                        end
                    end
                    k++;
                end
                stalled = mem_req_o && !mem_ready_i;
                prev_addr = mem_addr_o;
            end
            waited++;
            @(negedge clk);
        end
        if (!seen) check(1'b0, "R10 done never seen", 32'(waited), 32'd300);
        check(!busy_o && !done_o, "R10 idle after done", {30'd0, busy_o, done_o}, 32'd0);
    endtask

    initial begin : main
        logic [15:0] pats[8];
        int t = 0;
        pats = '{16'h0000, 16'hFFFF, 16'h00FF, 16'hFF00, 16'hA5C3, 16'h5A3C,
                 16'h8001, 16'h0180};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && !mem_req_o && !rf_we_o && !wb_en_o,
              "R10 reset state", {27'd0, busy_o, done_o, mem_req_o, rf_we_o, wb_en_o}, 32'd0);
        check(cycles_o == 8'd0 && final_addr_o == 32'd0, "R7 reset results",
              {24'd0, cycles_o}, 32'd0);

        for (int d = 0; d < 2; d++) begin
            for (int s = 0; s < 2; s++) begin
                for (int m = 2; m < 8; m++) begin
                    for (int p = 0; p < 24; p++) begin
                        logic [15:0] mk;
                        mk = (p < 8) ? pats[p] : (16'h0001 << (p - 8));
                        if (cyc < 150000) begin
                            run_xfer(d[0], s[0], 3'(m), mk, 32'h0000_1000 + 32'(t) * 32'h40);
                            t++;
                        end
                    end
                end
            end
        end
        if (cyc >= 150000) check(1'b0, "watchdog expired", 32'(cyc), 32'd150000);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule